// File: doc/BRIEF.md
# Local Bus Cycle Sequencer with Grant Arbiter

This block runs one local-bus access at a time on behalf of a bridge that has accepted a host-side target transaction. It also shares the local bus with one external bus master through a request/grant pair. When the bridge raises a pending request, the sequencer drives the address and raises an address-valid strobe. After a programmable number of local clocks it pulses the active-low address strobe `ads_n`. It then waits for the active-low ready input. The wait can optionally be cut short by a selectable timeout. When the access ends, for either reason, the block emits a one-cycle done pulse.

The grant policy is set by a configuration bit.
- In hold mode, an external master that already owns the bus keeps it for as long as it keeps requesting.
- In preempt mode, the grant is withdrawn as soon as a bridge request is pending. The sequencer then waits until the external master drops its request before it uses the bus.

The requester keeps `req_valid` high until it sees `done`, and drops it on the following clock edge. The external master must drop `ext_req` when its grant is withdrawn.

Top module: `lbus_cycle_seq`

## Requirements
- R1: During and right after reset, `ext_gnt`, `addr_valid`, `done` and `timeout_flag` are 0 and `ads_n` is 1.
- R2: The address-strobe delay code maps 0→0, 1→4, 2→8 and 3→16 clocks. `ads_n` is low in the cycle that lies that many cycles after the first cycle of `addr_valid`.
- R3: `ads_n` is low for exactly one clock per access, and only while `addr_valid` is high.
- R4: An access starts only when `ext_gnt` is 0, `ext_req` is 0 and no done pulse is present. `addr_valid` then rises one cycle after `req_valid` is seen under those conditions, and `ext_gnt` stays 0 throughout the access.
- R5: Wait cycles are the cycles after the `ads_n` cycle. If `rdy_n` is low in wait cycle k (counting from 0), `done` is high for one cycle in the next cycle, and `addr_valid` is low in that same cycle. `addr_out` holds the address captured at the start and stays unchanged while `addr_valid` is high.
- R6: With `cfg_to_en`=1 and `rdy_n` high throughout, the access ends after L wait cycles, where L is 32 when `cfg_to_sel`=0 and 64 when `cfg_to_sel`=1. `done` pulses in the next cycle and `timeout_flag` becomes 1. Ready arriving in the last wait cycle (k = L-1) ends the access normally.
- R7: With `cfg_to_en`=0, the sequencer waits for ready with no limit. Ready seen after 100 wait cycles still completes the access with `timeout_flag` unchanged.
- R8: With `cfg_grant_hold`=1, `ext_gnt` stays 1 while `ext_req` is 1, even with `req_valid` pending.
- R9: With `cfg_grant_hold`=0, `ext_gnt` falls one cycle after `req_valid` is seen with the grant active. No access starts and no new grant is given until `ext_req` falls.
- R10: While idle with no pending request, `ext_gnt` rises one cycle after `ext_req` rises. It falls one cycle after `ext_req` falls.
- R11: `timeout_flag` is sticky: once set, it stays 1 through later successful accesses until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bridge transaction pending |
| req_addr | input | AW | Address of the pending transaction |
| ext_req | input | 1 | External master bus request (active high) |
| rdy_n | input | 1 | Local ready, active low |
| cfg_ads_dly | input | 2 | Address-strobe delay code |
| cfg_to_en | input | 1 | Ready timeout enable |
| cfg_to_sel | input | 1 | Timeout length: 0 = 32, 1 = 64 clocks |
| cfg_grant_hold | input | 1 | 1 = let external master finish, 0 = preempt |
| ext_gnt | output | 1 | Grant to the external master (active high) |
| addr_valid | output | 1 | Address on `addr_out` is valid |
| addr_out | output | AW | Local-bus address |
| ads_n | output | 1 | Address strobe, active low, one clock |
| done | output | 1 | One-cycle pulse at the end of an access |
| timeout_flag | output | 1 | Sticky ready-timeout indication |

## Verification
The sequencing path is swept over every delay code, both timeout lengths and ready arriving in the first wait cycle, in a middle wait cycle and in the last wait cycle. This separates an off-by-one in the strobe delay from one in the ready counter, and it shows whether the final wait cycle still counts as a normal completion. Runs with no ready at all, for each code and length, pin the exact timeout cycle. A run with the timeout disabled and a late ready shows that the limit is really switched off.

The arbiter is driven in three situations: a plain request and release, a pending bridge request under hold mode, and the same under preempt mode. These tell apart a grant that is kept from one that is withdrawn. They also show that a start is deferred until the external request drops.

// File: rtl/lbus_seq_pkg.sv
// Shared types for the local bus cycle sequencer.
// Assumes: a single outstanding access; state encoding is free for synthesis.
package lbus_seq_pkg;

    // Sequencer phase of one local access
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // bus free for a new access or for the external master
        ST_DLY  = 2'd1,   // address valid, counting down to the strobe
        ST_ADS  = 2'd2,   // address strobe asserted for this single cycle
        ST_WAIT = 2'd3    // waiting for ready or timeout
    } seq_state_t;

endpackage

// File: rtl/lbus_grant_arb.sv
// Grant arbiter for the external local-bus master.
// Grants when the sequencer is idle with no bridge request pending; releases
// when the master drops its request or, in preempt mode, when a bridge request
// appears. Assumes the master drops ext_req once its grant is withdrawn.
module lbus_grant_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_req,
    input  logic req_pending,
    input  logic seq_busy,
    input  logic hold_mode,
    output logic ext_gnt
);

    logic gnt_q;
    logic gnt_d;

    // Next-grant decision from the current owner and pending work
    always_comb begin
        gnt_d = gnt_q;
        if (gnt_q) begin
            if (!ext_req)
                gnt_d = 1'b0;
            else if (!hold_mode && req_pending)
                gnt_d = 1'b0;
        end else if (ext_req && !seq_busy && !req_pending) begin
            gnt_d = 1'b1;
        end
    end

    // Grant register
    always_ff @(posedge clk) begin
        if (!rst_n)
            gnt_q <= 1'b0;
        else
            gnt_q <= gnt_d;
    end

    assign ext_gnt = gnt_q;

endmodule

// File: rtl/lbus_ads_delay.sv
// Address-strobe delay counter.
// Decodes the 2-bit delay code into a clock count, loads it when an access
// starts, and flags the last counting cycle. Assumes load is a single pulse.
module lbus_ads_delay #(
    parameter int D_CODE1 = 4,
    parameter int D_CODE2 = 8,
    parameter int D_CODE3 = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] code,
    output logic       is_zero,
    output logic       last
);

    localparam int DMAX = (D_CODE3 > D_CODE2) ? ((D_CODE3 > D_CODE1) ? D_CODE3 : D_CODE1)
                                              : ((D_CODE2 > D_CODE1) ? D_CODE2 : D_CODE1);
    localparam int CW   = $clog2(DMAX + 1);

    logic [CW-1:0] init;
    logic [CW-1:0] cnt;

    // Decode the delay code into a clock count
    always_comb begin
        case (code)
            2'd1:    init = CW'(D_CODE1);
            2'd2:    init = CW'(D_CODE2);
            2'd3:    init = CW'(D_CODE3);
            default: init = '0;
        endcase
    end

    // Down-counter, reloaded at access start
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= init;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign is_zero = (init == '0);
    assign last    = (cnt == CW'(1));

endmodule

// File: rtl/lbus_rdy_timer.sv
// Ready-wait counter.
// Counts wait cycles while run is high and reports the final allowed cycle
// for the selected limit. Cleared whenever run is low.
module lbus_rdy_timer #(
    parameter int TO_SHORT = 32,
    parameter int TO_LONG  = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sel_long,
    output logic at_limit
);

    localparam int TMAX = (TO_LONG > TO_SHORT) ? TO_LONG : TO_SHORT;
    localparam int TW   = $clog2(TMAX + 1);

    logic [TW-1:0] cnt;
    logic [TW-1:0] lim_m1;

    // Pick the last allowed wait-cycle index
    assign lim_m1 = sel_long ? TW'(TO_LONG - 1) : TW'(TO_SHORT - 1);

    // Wait-cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign at_limit = run && (cnt == lim_m1);

endmodule

// File: rtl/lbus_cycle_seq.sv
// Local bus cycle sequencer with external-master arbiter (top).
// Runs one bridge access: address valid, delayed one-clock strobe, wait for
// ready or an optional timeout, done pulse. Shares the bus with an external
// master through lbus_grant_arb. Assumes req_valid and req_addr stay stable
// until done is seen.
module lbus_cycle_seq
    import lbus_seq_pkg::*;
#(
    parameter int AW       = 16,
    parameter int D_CODE1  = 4,
    parameter int D_CODE2  = 8,
    parameter int D_CODE3  = 16,
    parameter int TO_SHORT = 32,
    parameter int TO_LONG  = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          ext_req,
    input  logic          rdy_n,
    input  logic [1:0]    cfg_ads_dly,
    input  logic          cfg_to_en,
    input  logic          cfg_to_sel,
    input  logic          cfg_grant_hold,
    output logic          ext_gnt,
    output logic          addr_valid,
    output logic [AW-1:0] addr_out,
    output logic          ads_n,
    output logic          done,
    output logic          timeout_flag
);

    seq_state_t st;
    logic       start;
    logic       busy;
    logic       dly_zero;
    logic       dly_last;
    logic       to_hit;

    assign busy  = (st != ST_IDLE);
    assign start = (st == ST_IDLE) && req_valid && !ext_gnt && !ext_req && !done;

    lbus_grant_arb i_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_req     (ext_req),
        .req_pending (req_valid),
        .seq_busy    (busy),
        .hold_mode   (cfg_grant_hold),
        .ext_gnt     (ext_gnt)
    );

    lbus_ads_delay #(
        .D_CODE1 (D_CODE1),
        .D_CODE2 (D_CODE2),
        .D_CODE3 (D_CODE3)
    ) i_dly (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start),
        .code    (cfg_ads_dly),
        .is_zero (dly_zero),
        .last    (dly_last)
    );

    lbus_rdy_timer #(
        .TO_SHORT (TO_SHORT),
        .TO_LONG  (TO_LONG)
    ) i_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (st == ST_WAIT),
        .sel_long (cfg_to_sel),
        .at_limit (to_hit)
    );

    // Access sequencing, address capture, done pulse and sticky timeout
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st           <= ST_IDLE;
            addr_valid   <= 1'b0;
            addr_out     <= '0;
            done         <= 1'b0;
            timeout_flag <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        addr_out   <= req_addr;
                        addr_valid <= 1'b1;
                        st         <= dly_zero ? ST_ADS : ST_DLY;
                    end
                end
                ST_DLY: begin
                    if (dly_last)
                        st <= ST_ADS;
                end
                ST_ADS: begin
                    st <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (!rdy_n) begin
                        done       <= 1'b1;
                        addr_valid <= 1'b0;
                        st         <= ST_IDLE;
                    end else if (cfg_to_en && to_hit) begin
                        done         <= 1'b1;
                        addr_valid   <= 1'b0;
                        timeout_flag <= 1'b1;
                        st           <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Strobe is a pure decode of the one-cycle strobe phase
    assign ads_n = (st != ST_ADS);

endmodule

// File: rtl/lbus_cycle_seq_chk.sv
// Property checker for lbus_cycle_seq, attached by bind.
// Observes ports only; all properties are disabled during reset.
module lbus_cycle_seq_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          ext_req,
    input logic          cfg_grant_hold,
    input logic          ext_gnt,
    input logic          addr_valid,
    input logic [AW-1:0] addr_out,
    input logic          ads_n,
    input logic          done,
    input logic          timeout_flag
);

    p_ads_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ads_n |=> ads_n);

    p_ads_in_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ads_n |-> addr_valid);

    p_start_bus_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_valid && !$past(addr_valid) && rst_n) ##1 addr_valid |-> $past(!ext_gnt && !ext_req && !done));

    p_no_grant_in_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> !ext_gnt);

    p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> (!addr_valid || $stable(addr_out)));

    p_done_drops_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !addr_valid);

    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_flag_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!timeout_flag ##1 timeout_flag) |-> done);

    p_hold_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_gnt && ext_req && cfg_grant_hold) |=> ext_gnt);

    p_preempt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_gnt && req_valid && !cfg_grant_hold) |=> !ext_gnt);

    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_gnt && !ext_req) |=> !ext_gnt);

    p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_flag |=> timeout_flag);

endmodule

bind lbus_cycle_seq lbus_cycle_seq_chk #(.AW(AW)) i_chk (.*);

// File: tb/test_lbus_cycle_seq.sv
// Self-checking bench for lbus_cycle_seq: sweeps delay codes, timeout lengths
// and ready positions, plus grant hold/preempt scenarios.
module test_lbus_cycle_seq;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic [AW-1:0] req_addr;
    logic          ext_req;
    logic          rdy_n;
    logic [1:0]    cfg_ads_dly;
    logic          cfg_to_en;
    logic          cfg_to_sel;
    logic          cfg_grant_hold;
    logic          ext_gnt;
    logic          addr_valid;
    logic [AW-1:0] addr_out;
    logic          ads_n;
    logic          done;
    logic          timeout_flag;

    int checks = 0;
    int errs   = 0;
    bit exp_flag = 1'b0;
    logic [AW-1:0] next_addr = 16'h1000;

    always #5 clk = ~clk;

    lbus_cycle_seq #(.AW(AW)) i_lbus_cycle_seq (.*);

    // Count one check and report a mismatch
    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Follow one access at negedges: record valid, strobe and done cycles
    task automatic serve(input int k, input logic [AW-1:0] addr,
                         output int av, output int a, output int d,
                         output int nads, output bit addr_bad);
        av = -1; a = -1; d = -1; nads = 0; addr_bad = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (addr_valid && av < 0) av = i;
            if (addr_valid && addr_out !== addr) addr_bad = 1'b1;
            if (!ads_n) begin
                nads++;
                if (a < 0) a = i;
            end
            if (done) begin
                d = i;
                req_valid = 1'b0;
                rdy_n = 1'b1;
                break;
            end
            rdy_n = (a >= 0 && (i - a - 1) == k) ? 1'b0 : 1'b1;
        end
    endtask

    // Launch one access from an idle bus and check all its timing
    task automatic do_access(input int code, input bit sel, input bit en, input int k);
        int av, a, d, nads, lim, dly, exp_d;
        bit bad;
        logic [AW-1:0] addr;
        @(negedge clk);
        addr = next_addr;
        next_addr = next_addr + 16'h0104;
        cfg_ads_dly = 2'(code);
        cfg_to_sel = sel;
        cfg_to_en = en;
        req_addr = addr;
        req_valid = 1'b1;
        serve(k, addr, av, a, d, nads, bad);
        lim = sel ? 64 : 32;
        dly = (code == 0) ? 0 : (4 << (code - 1));
        if (!en || k < lim) exp_d = dly + k + 2;
        else begin
            exp_d = dly + lim + 1;
            exp_flag = 1'b1;
        end
        chk("R4", "start cycle", av, 0);
        chk("R2", "strobe offset", a, dly);
        chk("R3", "strobe count", nads, 1);
        if (!en)
            chk("R7", "done cycle, no limit", d, exp_d);
        else if (k >= lim)
            chk("R6", "timeout done cycle", d, exp_d);
        else
            chk("R5", "ready done cycle", d, exp_d);
        chk("R5", "address held", int'(bad), 0);
        chk("R5", "valid low at done", int'(addr_valid), 0);
        chk(exp_flag ? "R6" : "R11", "timeout flag", int'(timeout_flag), int'(exp_flag));
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

    initial begin
        int av, a, d, nads;
        bit bad;
        rst_n = 1'b0; req_valid = 1'b1; req_addr = '0; ext_req = 1'b1; rdy_n = 1'b0;
        cfg_ads_dly = 2'd0; cfg_to_en = 1'b1; cfg_to_sel = 1'b0; cfg_grant_hold = 1'b1;
        repeat (3) @(negedge clk);
        // R1: outputs during reset with busy-looking inputs
        chk("R1", "gnt in reset", int'(ext_gnt), 0);
        chk("R1", "valid in reset", int'(addr_valid), 0);
        chk("R1", "ads_n in reset", int'(ads_n), 1);
        chk("R1", "done in reset", int'(done), 0);
        chk("R1", "flag in reset", int'(timeout_flag), 0);
        req_valid = 1'b0; ext_req = 1'b0; rdy_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "gnt after reset", int'(ext_gnt), 0);
        chk("R1", "valid after reset", int'(addr_valid), 0);

        // R10: plain grant and release
        ext_req = 1'b1;
        @(negedge clk);
        chk("R10", "grant rises", int'(ext_gnt), 1);
        ext_req = 1'b0;
        @(negedge clk);
        chk("R10", "grant falls", int'(ext_gnt), 0);

        // R8: hold mode keeps the grant with a bridge request pending
        cfg_grant_hold = 1'b1; cfg_ads_dly = 2'd0;
        ext_req = 1'b1;
        @(negedge clk);
        req_addr = 16'hA5A5; req_valid = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R8", "grant held", int'(ext_gnt), 1);
            chk("R4", "no start under grant", int'(addr_valid), 0);
        end
        ext_req = 1'b0;
        @(negedge clk);
        chk("R10", "grant released", int'(ext_gnt), 0);
        chk("R4", "no start while grant high", int'(addr_valid), 0);
        serve(0, 16'hA5A5, av, a, d, nads, bad);
        chk("R4", "start after release", av, 0);
        chk("R5", "done after hold run", d, 2);

        // R9: preempt mode withdraws the grant, start waits for ext_req low
        cfg_grant_hold = 1'b0;
        @(negedge clk);
        ext_req = 1'b1;
        @(negedge clk);
        chk("R10", "grant before preempt", int'(ext_gnt), 1);
        req_addr = 16'h3C3C; req_valid = 1'b1;
        @(negedge clk);
        chk("R9", "grant withdrawn", int'(ext_gnt), 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R9", "no regrant", int'(ext_gnt), 0);
            chk("R9", "waits for ext_req low", int'(addr_valid), 0);
        end
        ext_req = 1'b0;
        serve(3, 16'h3C3C, av, a, d, nads, bad);
        chk("R9", "start after ext_req low", av, 0);
        chk("R5", "done after preempt run", d, 5);
        cfg_grant_hold = 1'b1;

        // R2 R5 R6: ready sweep across codes, lengths and wait positions
        for (int code = 0; code < 4; code++) begin
            for (int s = 0; s < 2; s++) begin
                do_access(code, s[0], 1'b1, 0);
                do_access(code, s[0], 1'b1, 5);
                do_access(code, s[0], 1'b1, (s == 1) ? 63 : 31);
            end
        end
        // R6: timeout for every code and length
        for (int code = 0; code < 4; code++) begin
            for (int s = 0; s < 2; s++)
                do_access(code, s[0], 1'b1, 100000);
        end
        // R7: no limit when disabled
        do_access(1, 1'b0, 1'b0, 100);
        // R11: flag survives a clean access
        do_access(2, 1'b1, 1'b1, 2);
        chk("R11", "flag still set", int'(timeout_flag), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

endmodule